// File: doc/BRIEF.md
# 5B Code Group Alignment Monitor

The monitor receives a serial stream of recovered 5B line bits from a 100 Mb/s link, one bit per cycle when a qualifying strobe is high. The group boundary is unknown when the stream arrives. The monitor slides a ten-bit window over the bits until it sees the start-of-stream delimiter: the J group followed at once by the K group. That match fixes the group boundary.

From that point the boundary does not move. Every following run of five valid bits is presented as one aligned symbol with a single-cycle strobe. Each symbol is classified against the set of legal 5B codes. An illegal group raises a one-cycle violation pulse, which a link status block uses to drive an error indicator.

When the link-up input falls, or reset is applied, the lock is dropped and the delimiter search starts again from an empty window.

Top module: `cg_align_mon`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `aligned`, `sym_valid` and `code_err` are all 0.
- R2: Lock is set only after J (11000) is followed at once by K (10001). In both groups the first-arriving bit is the leftmost bit shown. `aligned` rises in the cycle after the clock edge that samples the last bit of K.
- R3: Once locked, the boundary is frozen. A J/K pattern at any other bit offset does not change `aligned` or the grouping of later bits.
- R4: After lock, `sym_valid` pulses for exactly one cycle for every five bits taken with `bit_valid` high. The pulse comes in the cycle after the edge that samples the fifth bit. Cycles with `bit_valid` low neither add a bit nor produce a strobe.
- R5: `sym_out` carries the five bits of the group. The first-arriving bit is in bit 4 and the last is in bit 0.
- R6: The legal set is the 16 data codes (11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101) plus 11111, 11000, 10001, 01101, 00111 and 00100. `code_err` is 1 with the strobe of every other group and 0 with the strobe of a legal group.
- R7: While unaligned, no `sym_valid` and no `code_err` pulse is produced, whatever bits arrive.
- R8: `link_up` low clears the lock and the window. Bits received before the drop cannot combine with later bits to form the delimiter.
- R9: `code_err` is never high in a cycle where `sym_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link established; low drops the lock |
| bit_valid | input | 1 | `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial line bit after NRZI decoding |
| sym_out | output | 5 | Aligned group, first-arriving bit in bit 4 |
| sym_valid | output | 1 | One-cycle strobe for `sym_out` |
| aligned | output | 1 | Group boundary locked |
| code_err | output | 1 | One-cycle pulse for an illegal group |

## Verification
Some properties are checked by assertions on every cycle:
- a violation pulse never appears without a strobe;
- strobes never appear while unlocked and are never back to back;
- the phase counter stays within a group;
- the lock persists while the link is up and clears one cycle after the link falls;
- every rise of the lock follows a delimiter hit.

Other behaviour can only be shown by the bench scenarios:
- that the delimiter is recognised only in J-then-K order;
- that the boundary stays frozen against a misplaced delimiter;
- that all 32 patterns are classified correctly;
- that gaps in the bit strobe are skipped;
- that a partial delimiter cannot survive a link drop.

// File: rtl/cga_pkg.sv
package cga_pkg;

  localparam int SYM_W = 5;
  localparam int WIN_W = 2 * SYM_W;

  localparam logic [SYM_W-1:0] GRP_J = 5'b11000;
  localparam logic [SYM_W-1:0] GRP_K = 5'b10001;
  localparam logic [WIN_W-1:0] SSD_PAIR = {GRP_J, GRP_K};

  // New bit enters at the low end; oldest bit leaves at the top.
  function automatic logic [WIN_W-1:0] cga_push(input logic [WIN_W-1:0] w,
                                                 input logic b);
    return {w[WIN_W-2:0], b};
  endfunction

  // Legal 5B groups: sixteen data codes and six control codes.
  function automatic logic cga_is_legal(input logic [SYM_W-1:0] s);
    case (s)
      5'b11110, 5'b01001, 5'b10100, 5'b10101,
      5'b01010, 5'b01011, 5'b01110, 5'b01111,
      5'b10010, 5'b10011, 5'b10110, 5'b10111,
      5'b11010, 5'b11011, 5'b11100, 5'b11101: return 1'b1;
      5'b11111, 5'b11000, 5'b10001,
      5'b01101, 5'b00111, 5'b00100:            return 1'b1;
      default:                                 return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cga_shifter.sv
module cga_shifter #(
  parameter int WIN_W = cga_pkg::WIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIN_W-1:0] win_next
);
  logic [WIN_W-1:0] win_q;

  assign win_next = cga_pkg::cga_push(win_q, bit_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_q <= '0;
    else if (clr)      win_q <= '0;
    else if (shift_en) win_q <= win_next;
  end
endmodule

// File: rtl/cga_framer.sv
module cga_framer #(
  parameter int SYM_W = cga_pkg::SYM_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_en,
  input  logic ssd_match,
  output logic aligned,
  output logic jk_hit,
  output logic grp_tick
);
  localparam int PH_W = $clog2(SYM_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);

  logic [PH_W-1:0] phase_q;

  assign jk_hit   = !aligned && bit_en && ssd_match;
  assign grp_tick = aligned && bit_en && (phase_q == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned <= 1'b0;
      phase_q <= '0;
    end else if (clr) begin
      aligned <= 1'b0;
      phase_q <= '0;
    end else if (jk_hit) begin
      aligned <= 1'b1;
      phase_q <= '0;
    end else if (aligned && bit_en) begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PH_LAST);

  assert_idle_phase_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> phase_q == '0);
endmodule

// File: rtl/cga_classify.sv
module cga_classify #(
  parameter int SYM_W = cga_pkg::SYM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             grp_tick,
  input  logic [SYM_W-1:0] grp,
  output logic [SYM_W-1:0] sym_out,
  output logic             sym_valid,
  output logic             code_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_out   <= '0;
      sym_valid <= 1'b0;
      code_err  <= 1'b0;
    end else if (clr) begin
      sym_valid <= 1'b0;
      code_err  <= 1'b0;
    end else begin
      sym_valid <= grp_tick;
      code_err  <= grp_tick && !cga_pkg::cga_is_legal(grp);
      if (grp_tick) sym_out <= grp;
    end
  end

  assert_err_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> sym_valid);
endmodule

// File: rtl/cg_align_mon.sv
module cg_align_mon #(
  parameter int SYM_W = cga_pkg::SYM_W,
  parameter int WIN_W = cga_pkg::WIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic [SYM_W-1:0] sym_out,
  output logic             sym_valid,
  output logic             aligned,
  output logic             code_err
);
  logic             clr;
  logic             bit_en;
  logic [WIN_W-1:0] win_next;
  logic             ssd_match;
  logic             jk_hit;
  logic             grp_tick;

  assign clr       = !link_up;
  assign bit_en    = bit_valid && link_up;
  assign ssd_match = (win_next == cga_pkg::SSD_PAIR);

  cga_shifter #(.WIN_W(WIN_W)) shifter_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(bit_en),
    .bit_in(bit_in), .win_next(win_next)
  );

  cga_framer #(.SYM_W(SYM_W)) framer_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(bit_en),
    .ssd_match(ssd_match), .aligned(aligned), .jk_hit(jk_hit),
    .grp_tick(grp_tick)
  );

  cga_classify #(.SYM_W(SYM_W)) classify_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .grp_tick(grp_tick),
    .grp(win_next[SYM_W-1:0]), .sym_out(sym_out),
    .sym_valid(sym_valid), .code_err(code_err)
  );

  assert_no_strobe_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> aligned);

  assert_link_drop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (!aligned && !sym_valid && !code_err));

  assert_lock_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && link_up) |=> aligned);

  assert_lock_from_delim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> $past(jk_hit));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);
endmodule

// File: tb/cg_align_mon_tb_top.sv
module cg_align_mon_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_up = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic [4:0] sym_out;
  logic       sym_valid;
  logic       aligned;
  logic       code_err;

  int checks = 0;
  int errors = 0;
  int strobes_seen = 0;
  int strobes_exp = 0;
  bit done = 1'b0;

  // Bench-side model of the requirements
  bit         m_aligned = 1'b0;
  logic [9:0] m_hist = '0;
  int         m_phase = 0;
  logic [4:0] m_acc = '0;
  logic [4:0] exp_q[$];

  always #5 clk = ~clk;

  cg_align_mon dut_i (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .bit_valid(bit_valid),
    .bit_in(bit_in), .sym_out(sym_out), .sym_valid(sym_valid),
    .aligned(aligned), .code_err(code_err)
  );

  // Illegal patterns as a bit mask: values 0,1,2,3,5,6,8,12,16,25 (R6)
  function automatic bit illegal5(input logic [4:0] s);
    logic [31:0] mask = 32'h0201_116F;
    return mask[s];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
    bit_valid = 1'b1;
    m_hist = {m_hist[8:0], b};
    if (!m_aligned) begin
      if (m_hist == 10'b11000_10001) begin
        m_aligned = 1'b1;
        m_phase = 0;
      end
    end else begin
      m_acc = {m_acc[3:0], b};
      m_phase++;
      if (m_phase == 5) begin
        exp_q.push_back(m_acc);
        strobes_exp++;
        m_phase = 0;
      end
    end
    @(posedge clk);
    #1;
    bit_valid = 1'b0;
    check(aligned == m_aligned, "R2/R3 aligned", aligned, m_aligned);
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic drop_link();
    idle(3);
    @(negedge clk);
    link_up = 1'b0;
    m_aligned = 1'b0; m_hist = '0; m_phase = 0;
    idle(2);
    #1;
    check(aligned == 1'b0, "R8 aligned after link drop", aligned, 0);
    check(sym_valid == 1'b0, "R8 strobe after link drop", sym_valid, 0);
    @(negedge clk);
    link_up = 1'b1;
  endtask

  // Output monitor: every strobe is matched against the bench's grouping
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (code_err && !sym_valid)
        check(1'b0, "R9 code_err without strobe", code_err, 0);
      if (sym_valid) begin
        strobes_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7/R4 unexpected strobe", sym_out, -1);
        end else begin
          logic [4:0] e;
          e = exp_q.pop_front();
          check(sym_out == e, "R5 symbol value", sym_out, e);
          check(code_err == illegal5(e), "R6 violation flag", code_err, illegal5(e));
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    #1;
    check(aligned == 0, "R1 reset aligned", aligned, 0);
    check(sym_valid == 0, "R1 reset strobe", sym_valid, 0);
    check(code_err == 0, "R1 reset code_err", code_err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    link_up = 1'b1;
    @(posedge clk); #1;
    check(aligned == 0 && sym_valid == 0, "R1 first cycle after reset", aligned, 0);

    // Unaligned junk: illegal groups, lone J, K before J. No lock, no reports (R7, R2)
    send_grp(5'b00000); send_grp(5'b00000); send_grp(5'b11001);
    send_grp(5'b11000); send_grp(5'b11111); send_grp(5'b10001);
    send_grp(5'b11000);
    idle(3); #1;
    check(aligned == 0, "R2 no lock without J then K", aligned, 0);

    // Partial J, link drop, remainder: must not lock (R8)
    send_bit(1); send_bit(1); send_bit(0);
    drop_link();
    send_bit(0); send_bit(0); send_bit(1); send_bit(0); send_bit(0);
    send_bit(0); send_bit(1);
    idle(2); #1;
    check(aligned == 0, "R8 partial delimiter lost", aligned, 0);

    // Lock, then all 32 patterns with strobe gaps (R2, R4, R5, R6)
    send_grp(5'b11000); send_grp(5'b10001);
    check(aligned == 1, "R2 lock after K", aligned, 1);
    for (int v = 0; v < 32; v++) begin
      for (int i = 4; i >= 0; i--) begin
        send_bit(v[i]);
        if (((v * 5 + (4 - i)) % 7) == 3) idle(2);
      end
    end

    // Misplaced delimiter at offset 3: grouping stays frozen (R3)
    send_bit(1); send_bit(0); send_bit(1);
    send_grp(5'b11000); send_grp(5'b10001);
    send_bit(1); send_bit(1);
    idle(3); #1;
    check(aligned == 1, "R3 lock kept over misplaced delimiter", aligned, 1);

    // Link drop, junk while unlocked, relock and sweep again (R8, R7)
    drop_link();
    send_grp(5'b00000); send_grp(5'b11001); send_grp(5'b10000);
    send_grp(5'b11000); send_grp(5'b10001);
    for (int v = 31; v >= 0; v--) send_grp(v[4:0]);

    // Reset mid-lock (R1)
    idle(3);
    @(negedge clk);
    rst_n = 1'b0;
    m_aligned = 1'b0; m_hist = '0; m_phase = 0;
    idle(1); #1;
    check(aligned == 0 && sym_valid == 0 && code_err == 0,
          "R1 reset clears lock", aligned, 0);
    @(negedge clk);
    rst_n = 1'b1;
    send_grp(5'b11000); send_grp(5'b10001);
    send_grp(5'b00100); send_grp(5'b00011);
    idle(4);

    check(exp_q.size() == 0, "R4 all expected symbols seen", exp_q.size(), 0);
    check(strobes_seen == strobes_exp, "R4 strobe count", strobes_seen, strobes_exp);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule